// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master transaction from a single 16-bit command word. It sits between a register bank and a bit-level bus engine. Software first loads the transmit FIFO with the address bytes and any write data, sets the data count, and writes the command. The sequencer then issues byte-level operations to the engine: start, repeated start, write byte, read byte with a chosen ACK or NACK reply, and stop. Each operation uses a request/done handshake. The sequencer collects the slave's acknowledge on every written byte and pushes each received byte into the receive FIFO.

It covers three kinds of transfer. A plain write and a plain read each send one slave-address byte. A combined transfer sends a slave address and up to six register-address bytes, issues a repeated start, sends the post-restart address, and then moves the data bytes. When the transaction ends, the block raises an interrupt-pending flag that is cleared by writing 1. Sticky flags report a slave NACK, a bus error and lost arbitration. A bus-busy flag is high from START until STOP.

Top module: `i2c_txn_seq`

## Requirements
- R1: A command write is accepted only when the block is idle and enabled and the command has bit 0 (start), bit 11 (master) and bit 15 (FIFO mode) all set. Any other command write, and every command write while a transaction runs, issues no operation.
- R2: After START, the address phase takes bytes from the transmit FIFO. With bit 4 clear it is exactly one byte. With bit 4 set it is bits [3:1] bytes, then a repeated START, then bits [7:5] bytes. A field value of 0 counts as 1.
- R3: Bit 0 of the first byte of the last address phase selects the data direction: 1 means read, 0 means write.
- R4: With bit 8 set, the data phase moves min(data_count, 240) bytes. With bit 8 clear, it moves none. Writes take bytes from the transmit FIFO.
- R5: Every read byte is answered with ACK, except that with bit 9 set the final byte is answered with NACK. Received bytes enter the receive FIFO in the order they arrive.
- R6: With bit 10 set, a STOP follows the last byte and bus_busy falls. With bit 10 clear, the transaction ends with bus_busy still high. bus_busy rises once START completes.
- R7: A NACK reported on a written byte while nack_ignore is low sets rx_nack and ends the transfer with a STOP. While nack_ignore is high, the transfer continues unchanged.
- R8: A bus error or lost arbitration reported on any operation sets bus_err or arb_lost and ends the transaction without a STOP. bus_busy goes low.
- R9: irq rises when a transaction ends and stays high until irq_clr is pulsed.
- R10: A sw_stop pulse during a transaction, or while idle with the bus held, leads to a STOP once the current operation completes. The bus is then released and irq is raised.
- R11: While enable is low, the block returns to idle at the next edge: op_req is low and bus_busy is low.
- R12: tx_full is high when the transmit FIFO holds FIFO_DEPTH bytes, and rx_not_empty is high when the receive FIFO holds any byte. A flush pulse empties its FIFO at the next edge.
- R13: op_req stays high, with op_code and op_wdata stable, until op_done. The op_code values are 1 start, 2 repeated start, 3 write, 4 read and 5 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Block enable |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word |
| data_count | input | 8 | Data-phase byte count |
| nack_ignore | input | 1 | Continue past a slave NACK |
| sw_stop | input | 1 | Software stop request |
| irq_clr | input | 1 | Clear interrupt pending |
| tx_push | input | 1 | Push into transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| tx_flush | input | 1 | Empty transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop receive FIFO |
| rx_flush | input | 1 | Empty receive FIFO |
| rx_data | output | 8 | Receive FIFO head byte |
| rx_not_empty | output | 1 | Receive FIFO holds data |
| op_req | output | 1 | Operation request to bit engine |
| op_code | output | 3 | Operation code |
| op_wdata | output | 8 | Byte to write |
| op_send_ack | output | 1 | Reply ACK (1) or NACK (0) on a read |
| op_done | input | 1 | Operation complete |
| op_rdata | input | 8 | Byte read |
| op_nack | input | 1 | Slave NACKed the written byte |
| op_arb_lost | input | 1 | Arbitration lost |
| op_bus_err | input | 1 | Bus error |
| bus_busy | output | 1 | Bus held between START and STOP |
| rx_nack | output | 1 | NACK flag |
| bus_err | output | 1 | Bus error flag |
| arb_lost | output | 1 | Arbitration lost flag |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions check the following properties on every cycle:
- the engine handshake holds its request and data steady until done;
- a disable empties the sequencer;
- the data counter stays within 1 to 240 during the data phase;
- a NACK leads straight to STOP;
- a bus error or lost arbitration drops the bus without a STOP;
- a pending interrupt holds until it is cleared.

The following can only be shown by the bench's scenarios, which compare the complete operation stream against expected results:
- that the address phases have the right lengths;
- that the direction is taken from the right byte;
- the exact ACK pattern on reads;
- the order of the bytes moved through both FIFOs;
- the cap of 240 bytes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_RSTART, S_ADDR2, S_DATA, S_STOP, S_FIN
  } seq_st_e;

  // command word layout (bit positions decoded by the register bank)
  typedef struct packed {
    logic       fifo_mode;   // 15
    logic [2:0] rsvd;        // 14:12
    logic       master;      // 11
    logic       stop_en;     // 10
    logic       last_nack;   // 9
    logic       cnt_en;      // 8
    logic [2:0] post_len;    // 7:5
    logic       restart;     // 4
    logic [2:0] addr_len;    // 3:1
    logic       start;       // 0
  } cmd_t;

  // address-phase length: a zero field still sends the slave address
  function automatic logic [CNT_W-1:0] phase_len(input logic [2:0] fld);
    return (fld == 3'd0) ? CNT_W'(1) : CNT_W'(fld);
  endfunction

  // data-phase length with count enable and the transfer cap
  function automatic logic [CNT_W-1:0] data_len(input logic en,
                                                input logic [CNT_W-1:0] dc,
                                                input logic [CNT_W-1:0] cap);
    if (!en)           return '0;
    else if (dc > cap) return cap;
    else               return dc;
  endfunction

endpackage

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);  // R12
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);  // R12

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int MAX_DATA = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_word,
  input  logic [CNT_W-1:0] data_count,
  input  logic             nack_ignore,
  input  logic             sw_stop,
  input  logic             irq_clr,
  input  logic             tx_empty,
  input  logic [7:0]       tx_head,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_wdata,
  output logic             op_req,
  output logic [2:0]       op_code,
  output logic [7:0]       op_wdata,
  output logic             op_send_ack,
  input  logic             op_done,
  input  logic [7:0]       op_rdata,
  input  logic             op_nack,
  input  logic             op_arb_lost,
  input  logic             op_bus_err,
  output logic             bus_busy,
  output logic             rx_nack,
  output logic             bus_err,
  output logic             arb_lost,
  output logic             irq_pending
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_DATA);

  seq_st_e          state;
  cmd_t             cmd_in;
  logic             restart_q, last_nack_q, stop_q;
  logic [2:0]       alen_q, post_q;
  logic [CNT_W-1:0] dlen_q, cnt;
  logic             rw_q, first_q, stop_pend;

  // named internal events
  logic    accept, fire, wr_nack, fault, last_byte;
  seq_st_e end_state, data_entry;
  logic    cmd_unused;

  assign cmd_in     = cmd_t'(cmd_word);
  assign cmd_unused = ^cmd_in.rsvd;
  assign accept     = (state == S_IDLE) && cmd_wr && cmd_in.start &&
                      cmd_in.master && cmd_in.fifo_mode;
  assign fire       = op_req && op_done;
  assign wr_nack    = op_nack && (op_code == OP_WRITE) && !nack_ignore;
  assign fault      = op_arb_lost || op_bus_err;
  assign last_byte  = (cnt == CNT_W'(1));
  assign end_state  = stop_q ? S_STOP : S_FIN;
  assign data_entry = (dlen_q == '0) ? end_state : S_DATA;

  always_comb begin
    op_req      = 1'b0;
    op_code     = OP_NONE;
    op_wdata    = 8'h00;
    op_send_ack = 1'b1;
    case (state)
      S_START:  begin op_req = 1'b1; op_code = OP_START; end
      S_RSTART: begin op_req = 1'b1; op_code = OP_RSTART; end
      S_STOP:   begin op_req = 1'b1; op_code = OP_STOP; end
      S_ADDR, S_ADDR2: begin
        op_req = !tx_empty; op_code = OP_WRITE; op_wdata = tx_head;
      end
      S_DATA: begin
        if (rw_q) begin
          op_req = 1'b1; op_code = OP_READ;
          op_send_ack = !(last_nack_q && last_byte);
        end else begin
          op_req = !tx_empty; op_code = OP_WRITE; op_wdata = tx_head;
        end
      end
      default: ;
    endcase
  end

  assign tx_pop   = fire && (op_code == OP_WRITE);
  assign rx_push  = fire && (op_code == OP_READ);
  assign rx_wdata = op_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; restart_q <= 1'b0; last_nack_q <= 1'b0; stop_q <= 1'b0;
      alen_q <= '0; post_q <= '0; dlen_q <= '0; cnt <= '0;
      rw_q <= 1'b0; first_q <= 1'b0; stop_pend <= 1'b0;
      bus_busy <= 1'b0; rx_nack <= 1'b0; bus_err <= 1'b0; arb_lost <= 1'b0;
      irq_pending <= 1'b0;
    end else if (!enable) begin
      state <= S_IDLE; bus_busy <= 1'b0; stop_pend <= 1'b0;
      if (irq_clr) irq_pending <= 1'b0;
    end else begin
      if (irq_clr) irq_pending <= 1'b0;
      if (sw_stop && state != S_IDLE && state != S_STOP && state != S_FIN)
        stop_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (accept) begin
            restart_q <= cmd_in.restart; alen_q <= cmd_in.addr_len;
            post_q <= cmd_in.post_len; last_nack_q <= cmd_in.last_nack;
            stop_q <= cmd_in.stop_en;
            dlen_q <= data_len(cmd_in.cnt_en, data_count, CAP);
            rx_nack <= 1'b0; bus_err <= 1'b0; arb_lost <= 1'b0;
            state <= S_START;
          end else if (sw_stop && bus_busy) begin
            state <= S_STOP;
          end
        end
        S_FIN: begin
          irq_pending <= 1'b1;
          stop_pend   <= 1'b0;
          state       <= S_IDLE;
        end
        default: begin
          if (fire) begin
            if (state == S_START) bus_busy <= 1'b1;
            if (op_arb_lost) begin
              arb_lost <= 1'b1; bus_busy <= 1'b0; state <= S_FIN;
            end else if (op_bus_err) begin
              bus_err <= 1'b1; bus_busy <= 1'b0; state <= S_FIN;
            end else if (wr_nack) begin
              rx_nack <= 1'b1; state <= S_STOP;
            end else if (state == S_STOP) begin
              bus_busy <= 1'b0; state <= S_FIN;
            end else if (stop_pend) begin
              state <= S_STOP;
            end else begin
              case (state)
                S_START: begin
                  cnt <= restart_q ? phase_len(alen_q) : CNT_W'(1);
                  first_q <= 1'b1; state <= S_ADDR;
                end
                S_ADDR, S_ADDR2: begin
                  first_q <= 1'b0;
                  if (first_q) rw_q <= op_wdata[0];
                  cnt <= cnt - 1'b1;
                  if (last_byte) begin
                    if (state == S_ADDR && restart_q) begin
                      state <= S_RSTART;
                    end else begin
                      state <= data_entry; cnt <= dlen_q;
                    end
                  end
                end
                S_RSTART: begin
                  cnt <= phase_len(post_q); first_q <= 1'b1; state <= S_ADDR2;
                end
                S_DATA: begin
                  cnt <= cnt - 1'b1;
                  if (last_byte) state <= end_state;
                end
                default: state <= S_IDLE;
              endcase
            end
          end else if (stop_pend && !op_req && state != S_STOP) begin
            state <= S_STOP;
          end
        end
      endcase
    end
  end

  AST_DATA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (cnt != '0 && cnt <= CAP));  // R4
  AST_READ_NACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_code == OP_READ && !op_send_ack) |-> (last_byte && last_nack_q));  // R5
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fire && op_code == OP_START && !fault) |=> bus_busy);  // R6
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fire && wr_nack && !fault) |=> (state == S_STOP && rx_nack));  // R7
  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fire && fault) |=> (!bus_busy && state == S_FIN));  // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending);  // R9

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_DATA   = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_word,
  input  logic [CNT_W-1:0] data_count,
  input  logic             nack_ignore,
  input  logic             sw_stop,
  input  logic             irq_clr,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  input  logic             tx_flush,
  output logic             tx_full,
  input  logic             rx_pop,
  input  logic             rx_flush,
  output logic [7:0]       rx_data,
  output logic             rx_not_empty,
  output logic             op_req,
  output logic [2:0]       op_code,
  output logic [7:0]       op_wdata,
  output logic             op_send_ack,
  input  logic             op_done,
  input  logic [7:0]       op_rdata,
  input  logic             op_nack,
  input  logic             op_arb_lost,
  input  logic             op_bus_err,
  output logic             bus_busy,
  output logic             rx_nack,
  output logic             bus_err,
  output logic             arb_lost,
  output logic             irq
);
  logic       tx_empty, tx_pop, rx_push, rx_empty, rx_full_unused;
  logic [7:0] tx_head, rx_wdata;

  i2c_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .din(tx_data), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full));

  i2c_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_wdata), .pop(rx_pop),
    .head(rx_data), .empty(rx_empty), .full(rx_full_unused));

  assign rx_not_empty = !rx_empty;

  i2c_seq_fsm #(.MAX_DATA(MAX_DATA)) i_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .data_count(data_count),
    .nack_ignore(nack_ignore), .sw_stop(sw_stop), .irq_clr(irq_clr),
    .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_wdata(rx_wdata),
    .op_req(op_req), .op_code(op_code), .op_wdata(op_wdata),
    .op_send_ack(op_send_ack), .op_done(op_done), .op_rdata(op_rdata),
    .op_nack(op_nack), .op_arb_lost(op_arb_lost), .op_bus_err(op_bus_err),
    .bus_busy(bus_busy), .rx_nack(rx_nack), .bus_err(bus_err),
    .arb_lost(arb_lost), .irq_pending(irq));

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_done && enable && !tx_flush) |=>
      (!enable || (op_req && $stable(op_code) && $stable(op_wdata))));  // R13
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!op_req && !bus_busy));  // R11

endmodule

// File: tb/test_i2c_txn_seq.sv
module test_i2c_txn_seq;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic enable = 0, cmd_wr = 0, nack_ignore = 0, sw_stop = 0, irq_clr = 0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  data_count = '0;
  logic tx_push = 0, tx_flush = 0, rx_pop = 0, rx_flush = 0;
  logic [7:0] tx_data = '0;
  logic tx_full, rx_not_empty, op_req, op_send_ack, bus_busy, rx_nack, bus_err, arb_lost, irq;
  logic [7:0] rx_data, op_wdata;
  logic [2:0] op_code;
  logic op_done = 0, op_nack = 0, op_arb_lost = 0, op_bus_err = 0;
  logic [7:0] op_rdata = '0;

  i2c_txn_seq #(.FIFO_DEPTH(DEPTH), .MAX_DATA(240)) i_i2c_txn_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .data_count(data_count), .nack_ignore(nack_ignore), .sw_stop(sw_stop),
    .irq_clr(irq_clr), .tx_push(tx_push), .tx_data(tx_data), .tx_flush(tx_flush),
    .tx_full(tx_full), .rx_pop(rx_pop), .rx_flush(rx_flush), .rx_data(rx_data),
    .rx_not_empty(rx_not_empty), .op_req(op_req), .op_code(op_code),
    .op_wdata(op_wdata), .op_send_ack(op_send_ack), .op_done(op_done),
    .op_rdata(op_rdata), .op_nack(op_nack), .op_arb_lost(op_arb_lost),
    .op_bus_err(op_bus_err), .bus_busy(bus_busy), .rx_nack(rx_nack),
    .bus_err(bus_err), .arb_lost(arb_lost), .irq(irq));

  int n_vec = 0, n_bad = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-engine model: one cycle to accept, then a one-cycle done
  int n_ops = 0, rd_cnt = 0, nack_at = -1, err_at = -1, arb_at = -1;
  int log_code [512];
  logic [7:0] log_wd [512];
  logic log_ack [512];
  logic eng_busy = 0;
  int eng_idx = 0;
  logic [2:0] eng_code = '0;

  always @(posedge clk) begin
    op_done <= 0; op_nack <= 0; op_bus_err <= 0; op_arb_lost <= 0;
    if (!rst_n) eng_busy <= 0;
    else if (op_done) eng_busy <= 0;
    else if (eng_busy) begin
      op_done     <= 1;
      op_nack     <= (eng_idx == nack_at);
      op_bus_err  <= (eng_idx == err_at);
      op_arb_lost <= (eng_idx == arb_at);
      if (eng_code == 3'd4) begin
        op_rdata <= 8'h40 + 8'(rd_cnt);
        rd_cnt   <= rd_cnt + 1;
      end
    end else if (op_req) begin
      eng_busy <= 1; eng_idx <= n_ops; eng_code <= op_code;
      log_code[n_ops % 512] <= int'(op_code);
      log_wd[n_ops % 512]   <= op_wdata;
      log_ack[n_ops % 512]  <= op_send_ack;
      n_ops <= n_ops + 1;
    end
  end

  int exp_code [512];
  logic [7:0] exp_wd [512];
  logic exp_ack [512];
  int n_exp = 0;

  task automatic add_exp(int c, logic [7:0] w, logic a);
    exp_code[n_exp] = c; exp_wd[n_exp] = w; exp_ack[n_exp] = a; n_exp++;
  endtask

  task automatic push_byte(logic [7:0] b);
    tx_push = 1; tx_data = b; @(negedge clk); tx_push = 0;
  endtask

  task automatic pulse_cmd(logic [15:0] c, logic [7:0] dc);
    cmd_word = c; data_count = dc; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_irq(string req);
    int t = 0;
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    if (!irq) chk({req, " irq timeout"}, 0, 1);
  endtask

  task automatic clear_irq();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic cmp_ops(string req, int base);
    chk({req, " op count"}, n_ops - base, n_exp);
    for (int i = 0; i < n_exp && i < n_ops - base; i++) begin
      chk({req, " op code"}, log_code[(base + i) % 512], exp_code[i]);
      if (exp_code[i] == 3) chk({req, " write byte"}, int'(log_wd[(base + i) % 512]), int'(exp_wd[i]));
      if (exp_code[i] == 4) chk({req, " R5 ack"}, int'(log_ack[(base + i) % 512]), int'(exp_ack[i]));
    end
  endtask

  function automatic logic [15:0] mk_cmd(bit stp, bit ns, bit de, int post, bit rs, int alen);
    return 16'h8801 | (16'(stp) << 10) | (16'(ns) << 9) | (16'(de) << 8) |
           (16'(post & 7) << 5) | (16'(rs) << 4) | (16'(alen & 7) << 1);
  endfunction

  task automatic sweep_one(bit rs, int alen, int post, bit rd, int dc, bit ns, bit stp);
    int base = n_ops; int rbase = rd_cnt; int n1; int n2;
    logic [7:0] b;
    n_exp = 0;
    add_exp(1, 0, 1);
    n1 = rs ? ((alen == 0) ? 1 : alen) : 1;
    for (int i = 0; i < n1; i++) begin
      b = (i == 0) ? (rs ? 8'hA0 : (8'hA0 | 8'(rd))) : 8'h10 + 8'(i);
      push_byte(b); add_exp(3, b, 1);
    end
    if (rs) begin
      add_exp(2, 0, 1);
      n2 = (post == 0) ? 1 : post;
      for (int i = 0; i < n2; i++) begin
        b = (i == 0) ? (8'hA0 | 8'(rd)) : 8'h20 + 8'(i);
        push_byte(b); add_exp(3, b, 1);
      end
    end
    for (int k = 0; k < dc; k++) begin
      if (rd) add_exp(4, 0, !(ns && k == dc - 1));
      else begin b = 8'h50 + 8'(k); push_byte(b); add_exp(3, b, 1); end
    end
    if (stp) add_exp(5, 0, 1);
    pulse_cmd(mk_cmd(stp, ns, 1'b1, post, rs, alen), 8'(dc));
    wait_irq("R2/R3/R4 sweep");
    cmp_ops("R2/R3/R4 sweep", base);
    chk("R6 busy after end", int'(bus_busy), int'(!stp));
    clear_irq();
    chk("R9 irq cleared", int'(irq), 0);
    for (int k = 0; k < (rd ? dc : 0); k++) begin
      chk("R5 rx order", int'(rx_data), int'(8'h40 + 8'(rbase + k)));
      rx_pop = 1; @(negedge clk); rx_pop = 0;
    end
    chk("R12 rx drained", int'(rx_not_empty), 0);
    if (!stp) begin
      base = n_ops;
      sw_stop = 1; @(negedge clk); sw_stop = 0;
      wait_irq("R10 idle stop");
      chk("R10 idle stop op", (n_ops - base == 1) ? log_code[base % 512] : -1, 5);
      chk("R10 bus released", int'(bus_busy), 0);
      clear_irq();
    end
  endtask

  task automatic reset_fifos();
    tx_flush = 1; rx_flush = 1; @(negedge clk); tx_flush = 0; rx_flush = 0;
  endtask

  initial begin
    #(10 * 190000);
    chk("watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R11 reset op_req", int'(op_req), 0);
    chk("R6 reset bus_busy", int'(bus_busy), 0);
    chk("R9 reset irq", int'(irq), 0);
    chk("R12 reset tx_full", int'(tx_full), 0);
    chk("R12 reset rx empty", int'(rx_not_empty), 0);
    enable = 1; @(negedge clk);

    // near-exhaustive sweep of command fields
    for (int rs = 0; rs < 2; rs++)
      for (int alen = 0; alen < 4; alen++)
        for (int post = 1; post < 3; post++)
          for (int rd = 0; rd < 2; rd++)
            for (int dc = 0; dc < 4; dc += (dc == 0) ? 1 : 2)
              for (int stp = 0; stp < 2; stp++)
                sweep_one(rs[0], alen, post, rd[0], dc, alen[0], stp[0]);

    // R1: command missing the master bit is ignored
    base = n_ops;
    pulse_cmd(16'h8401 & ~16'h0800, 8'd0);
    repeat (10) @(negedge clk);
    chk("R1 no master no ops", n_ops - base, 0);
    chk("R1 no master no irq", int'(irq), 0);

    // R7: NACK on first data byte aborts with STOP
    base = n_ops;
    for (int i = 0; i < 4; i++) push_byte(8'hA0 + 8'(i));
    nack_at = base + 2;
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd3);
    wait_irq("R7 nack");
    chk("R7 nack op count", n_ops - base, 4);
    chk("R7 nack last op stop", log_code[(n_ops - 1) % 512], 5);
    chk("R7 rx_nack set", int'(rx_nack), 1);
    clear_irq(); reset_fifos();

    // R7: NACK ignored
    base = n_ops; nack_ignore = 1;
    for (int i = 0; i < 4; i++) push_byte(8'hA0 + 8'(i));
    nack_at = base + 2;
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd3);
    wait_irq("R7 ignore");
    chk("R7 ignore op count", n_ops - base, 6);
    chk("R7 ignore flag clear", int'(rx_nack), 0);
    clear_irq(); nack_ignore = 0; nack_at = -1;

    // R8: bus error on address byte, no STOP
    base = n_ops;
    for (int i = 0; i < 4; i++) push_byte(8'hA0 + 8'(i));
    err_at = base + 1;
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd3);
    wait_irq("R8 bus error");
    chk("R8 err op count", n_ops - base, 2);
    chk("R8 bus_err flag", int'(bus_err), 1);
    chk("R8 bus released", int'(bus_busy), 0);
    clear_irq(); reset_fifos(); err_at = -1;

    // R8: arbitration lost on START
    base = n_ops; push_byte(8'hA1);
    arb_at = base;
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd2);
    wait_irq("R8 arb");
    chk("R8 arb op count", n_ops - base, 1);
    chk("R8 arb flag", int'(arb_lost), 1);
    chk("R8 arb no busy", int'(bus_busy), 0);
    clear_irq(); reset_fifos(); arb_at = -1;

    // R1: command write while busy is ignored
    base = n_ops;
    for (int i = 0; i < 4; i++) push_byte(8'hA0 + 8'(i));
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd3);
    repeat (3) @(negedge clk);
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd1);
    wait_irq("R1 busy");
    chk("R1 busy cmd ignored", n_ops - base, 6);
    clear_irq();
    repeat (10) @(negedge clk);
    chk("R1 no second txn", n_ops - base, 6);

    // R10: software stop during a read
    base = n_ops; push_byte(8'hA1);
    pulse_cmd(mk_cmd(1, 1, 1, 0, 0, 1), 8'd5);
    while (n_ops - base < 3) @(negedge clk);
    sw_stop = 1; @(negedge clk); sw_stop = 0;
    wait_irq("R10 stop");
    chk("R10 stop last op", log_code[(n_ops - 1) % 512], 5);
    chk("R10 cut short", int'(n_ops - base < 8), 1);
    chk("R10 busy released", int'(bus_busy), 0);
    clear_irq(); reset_fifos();

    // R11: disable mid-transaction
    base = n_ops; push_byte(8'hA1);
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd5);
    while (n_ops - base < 2) @(negedge clk);
    enable = 0; @(negedge clk);
    chk("R11 req low", int'(op_req), 0);
    chk("R11 busy low", int'(bus_busy), 0);
    repeat (4) @(negedge clk);
    enable = 1; reset_fifos(); @(negedge clk);

    // R4: count cap and count disable
    base = n_ops; push_byte(8'hA1);
    pulse_cmd(mk_cmd(1, 0, 1, 0, 0, 1), 8'd250);
    wait_irq("R4 cap");
    chk("R4 capped reads", n_ops - base - 3, 240);
    chk("R12 rx not empty", int'(rx_not_empty), 1);
    clear_irq(); reset_fifos();
    chk("R12 rx flushed", int'(rx_not_empty), 0);
    base = n_ops; push_byte(8'hA1);
    pulse_cmd(mk_cmd(1, 0, 0, 0, 0, 1), 8'd5);
    wait_irq("R4 no count");
    chk("R4 count disabled", n_ops - base, 3);
    clear_irq();

    // R12: tx full and flush
    for (int i = 0; i < DEPTH; i++) push_byte(8'(i));
    chk("R12 tx full", int'(tx_full), 1);
    tx_flush = 1; @(negedge clk); tx_flush = 0;
    chk("R12 tx flushed", int'(tx_full), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule